// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a processor core that completes one 32-bit instruction in every clock cycle. In one combinational pass it fetches a word from a local instruction store, decodes it, reads two operands from a 32 x 32 register file, runs the ALU and, for loads, reads a local data store. The results are written to the register file, the data store and the program counter on the next rising edge. Control comes from two combinational tables. The first maps the six-bit opcode to the datapath selects. The second maps a two-bit ALU class and, for register-register instructions, the six-bit function code to a 3-bit ALU operation.

The instruction set is small. It has register-register `and`, `or`, `addu`, `subu` and `slt`, plus immediate add, word load, word store, branch-if-equal and an absolute jump. Both local stores are word-addressed arrays. A load port fills them while the core is held in reset. The core's own activity is visible on its outputs: the current PC, the current instruction, the register write port and the store write port.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, `pc_o` becomes 0 at the next rising edge, all 32 registers clear to 0, and `rf_we_o` and `dm_we_o` stay low. When `rst` falls, execution starts at PC 0.
- R2: Every instruction other than a branch or a jump moves the PC to PC+4. The instruction is fetched from word index PC[k+1:2], where k = log2 of the instruction store depth, so the index wraps at that depth.
- R3: Opcode 000000 writes register bits 15:11 with an ALU result. Bits 25:21 give source A and bits 20:16 give source B. The function code in bits 5:0 selects the operation: 100001 is A+B, 100011 is A-B, 100100 is A AND B, 100101 is A OR B, and 101010 is 1 when A<B as signed numbers, else 0.
- R4: Opcode 001001 writes register bits 20:16 with source A plus the sign-extended immediate in bits 15:0.
- R5: Opcode 100011 forms the address as source A plus the sign-extended immediate. It writes register bits 20:16 with the data word at index address[m+1:2], where m = log2 of the data store depth.
- R6: Opcode 101011 raises `dm_we_o` and writes source B to the data word at the same index as R5. It makes no register write.
- R7: Opcode 000100 makes no write. If source A equals source B, the next PC is PC+4+(sign-extended immediate << 2). Otherwise it is PC+4.
- R8: Opcode 000010 makes no write. The next PC is {PC+4 bits 31:28, instruction bits 25:0, 2'b00}.
- R9: Register 0 always reads as 0, and writes addressed to it are discarded.
- R10: Any other opcode makes no register write and no store write, and it advances the PC by 4.
- R11: With `ld_en` high, the word `ld_data` goes into the store chosen by `ld_dmem` (1 for data, 0 for instruction) at word index `ld_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Store load strobe |
| ld_dmem | input | 1 | Load target: 1 data store, 0 instruction store |
| ld_addr | input | LD_AW | Load word index |
| ld_data | input | 32 | Load word |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction at the current PC |
| rf_we_o | output | 1 | Register write enable this cycle |
| rf_waddr_o | output | 5 | Register write address |
| rf_wdata_o | output | 32 | Register write data |
| dm_we_o | output | 1 | Data store write enable this cycle |
| dm_addr_o | output | 32 | Data byte address from the ALU |
| dm_wdata_o | output | 32 | Data store write word |

## Verification
In one cycle a register can be written at the edge while the next instruction reads it combinationally. A taken branch can also depend on an operand that the previous instruction produced. The bench makes both happen. Short directed chains feed a fresh result straight into `slt`, `subu`, a store/load pair and a `beq`. A long constrained-random program then mixes dependent register choices with branches and jumps. A bench-side instruction model steps in lockstep with the core and judges every cycle by its PC, register write and store write.

// File: rtl/sc_pkg.sv
package sc_pkg;

   localparam logic [5:0] OPC_REG   = 6'b000000;
   localparam logic [5:0] OPC_LOAD  = 6'b100011;
   localparam logic [5:0] OPC_STORE = 6'b101011;
   localparam logic [5:0] OPC_BEQ   = 6'b000100;
   localparam logic [5:0] OPC_ADDI  = 6'b001001;
   localparam logic [5:0] OPC_JMP   = 6'b000010;

   localparam logic [5:0] FN_ADD = 6'b100001;
   localparam logic [5:0] FN_SUB = 6'b100011;
   localparam logic [5:0] FN_AND = 6'b100100;
   localparam logic [5:0] FN_OR  = 6'b100101;
   localparam logic [5:0] FN_SLT = 6'b101010;

   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_ctl_e;

   typedef enum logic [1:0] {
      CLS_ADD   = 2'b00,
      CLS_SUB   = 2'b01,
      CLS_FUNCT = 2'b10
   } alu_cls_e;

   typedef struct packed {
      logic     reg_write;
      logic     dst_rd;
      logic     src_imm;
      logic     branch;
      logic     mem_write;
      logic     wb_mem;
      alu_cls_e alu_cls;
      logic     jump;
   } ctrl_t;

endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
   import sc_pkg::*;
(
   input  logic [5:0] opcode,
   output ctrl_t      ctrl
);
   always_comb begin
      ctrl = '0;
      ctrl.alu_cls = CLS_ADD;
      unique case (opcode)
         OPC_REG: begin
            ctrl.reg_write = 1'b1;
            ctrl.dst_rd    = 1'b1;
            ctrl.alu_cls   = CLS_FUNCT;
         end
         OPC_LOAD: begin
            ctrl.reg_write = 1'b1;
            ctrl.src_imm   = 1'b1;
            ctrl.wb_mem    = 1'b1;
         end
         OPC_STORE: begin
            ctrl.src_imm   = 1'b1;
            ctrl.mem_write = 1'b1;
         end
         OPC_BEQ: begin
            ctrl.branch    = 1'b1;
            ctrl.alu_cls   = CLS_SUB;
         end
         OPC_ADDI: begin
            ctrl.reg_write = 1'b1;
            ctrl.src_imm   = 1'b1;
         end
         OPC_JMP: begin
            ctrl.jump      = 1'b1;
         end
         default: ctrl = '0;
      endcase
   end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
   import sc_pkg::*;
(
   input  alu_cls_e   cls,
   input  logic [5:0] funct,
   output alu_ctl_e   ctl
);
   always_comb begin
      ctl = ALU_ADD;
      case (cls)
         CLS_ADD: ctl = ALU_ADD;
         CLS_SUB: ctl = ALU_SUB;
         default: begin
            case (funct)
               FN_ADD:  ctl = ALU_ADD;
               FN_SUB:  ctl = ALU_SUB;
               FN_AND:  ctl = ALU_AND;
               FN_OR:   ctl = ALU_OR;
               FN_SLT:  ctl = ALU_SLT;
               default: ctl = ALU_ADD;
            endcase
         end
      endcase
   end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_ctl_e     ctl,
   output logic [W-1:0] y,
   output logic         zero
);
   logic [W-1:0] b_sel;
   logic [W-1:0] sum;
   logic         lt;

   always_comb begin
      b_sel = ctl[2] ? ~b : b;
      sum   = a + b_sel + {{(W-1){1'b0}}, ctl[2]};
      lt    = $signed(a) < $signed(b);
      unique case (ctl[1:0])
         2'b00: y = a & b_sel;
         2'b01: y = a | b_sel;
         2'b10: y = sum;
         default: y = {{(W-1){1'b0}}, lt};
      endcase
   end

   assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int W    = 32,
   parameter int NREG = 32,
   localparam int AW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   output logic [W-1:0]  rd1,
   output logic [W-1:0]  rd2
);
   logic [W-1:0] regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g == 0) begin : g_zero
         assign regs[g] = '0;
      end else begin : g_store
         always_ff @(posedge clk) begin
            if (rst) begin
               regs[g] <= '0;
            end else if (we && wa == AW'(g)) begin
               regs[g] <= wd;
            end
         end
      end
   end

   assign rd1 = regs[ra1];
   assign rd2 = regs[ra2];
endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int IMEM_WORDS = 64,
   parameter int DMEM_WORDS = 64,
   localparam int IAW   = $clog2(IMEM_WORDS),
   localparam int DAW   = $clog2(DMEM_WORDS),
   localparam int LD_AW = (IAW > DAW) ? IAW : DAW
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_en,
   input  logic             ld_dmem,
   input  logic [LD_AW-1:0] ld_addr,
   input  logic [31:0]      ld_data,
   output logic [31:0]      pc_o,
   output logic [31:0]      instr_o,
   output logic             rf_we_o,
   output logic [4:0]       rf_waddr_o,
   output logic [31:0]      rf_wdata_o,
   output logic             dm_we_o,
   output logic [31:0]      dm_addr_o,
   output logic [31:0]      dm_wdata_o
);
   if (IMEM_WORDS < 2 || (1 << IAW) != IMEM_WORDS) begin : g_bad_imem
      $error("IMEM_WORDS must be a power of two, at least 2");
   end
   if (DMEM_WORDS < 2 || (1 << DAW) != DMEM_WORDS) begin : g_bad_dmem
      $error("DMEM_WORDS must be a power of two, at least 2");
   end

   logic [31:0] pc;
   logic [31:0] instr;
   logic [31:0] imem [IMEM_WORDS];
   logic [31:0] dmem [DMEM_WORDS];
   ctrl_t       ctrl;
   alu_ctl_e    alu_ctl;
   logic [31:0] rd1, rd2;
   logic [31:0] simm;
   logic [31:0] src_b;
   logic [31:0] alu_y;
   logic        alu_zero;
   logic [4:0]  waddr;
   logic [31:0] rdata;
   logic [31:0] result;
   logic        rf_we;
   logic        dm_we;
   logic [31:0] pc_plus4;
   logic [31:0] pc_branch;
   logic [31:0] pc_seq_or_br;
   logic [31:0] pc_next;

   // instruction store
   always_ff @(posedge clk) begin
      if (ld_en && !ld_dmem) begin
         imem[ld_addr[IAW-1:0]] <= ld_data;
      end
   end
   assign instr = imem[pc[IAW+1:2]];

   sc_main_dec u_mdec (
      .opcode (instr[31:26]),
      .ctrl   (ctrl)
   );

   sc_alu_dec u_adec (
      .cls   (ctrl.alu_cls),
      .funct (instr[5:0]),
      .ctl   (alu_ctl)
   );

   assign waddr = ctrl.dst_rd ? instr[15:11] : instr[20:16];
   assign rf_we = ctrl.reg_write && !rst;

   sc_regfile #(.W(32), .NREG(32)) u_rf (
      .clk (clk),
      .rst (rst),
      .we  (rf_we),
      .wa  (waddr),
      .wd  (result),
      .ra1 (instr[25:21]),
      .ra2 (instr[20:16]),
      .rd1 (rd1),
      .rd2 (rd2)
   );

   assign simm  = {{16{instr[15]}}, instr[15:0]};
   assign src_b = ctrl.src_imm ? simm : rd2;

   sc_alu #(.W(32)) u_alu (
      .a    (rd1),
      .b    (src_b),
      .ctl  (alu_ctl),
      .y    (alu_y),
      .zero (alu_zero)
   );

   // data store
   assign dm_we = ctrl.mem_write && !rst;
   always_ff @(posedge clk) begin
      if (ld_en && ld_dmem) begin
         dmem[ld_addr[DAW-1:0]] <= ld_data;
      end else if (dm_we) begin
         dmem[alu_y[DAW+1:2]] <= rd2;
      end
   end
   assign rdata  = dmem[alu_y[DAW+1:2]];
   assign result = ctrl.wb_mem ? rdata : alu_y;

   // next PC: jump overrides the branch/sequential choice
   assign pc_plus4     = pc + 32'd4;
   assign pc_branch    = pc_plus4 + {simm[29:0], 2'b00};
   assign pc_seq_or_br = (ctrl.branch && alu_zero) ? pc_branch : pc_plus4;
   assign pc_next      = ctrl.jump ? {pc_plus4[31:28], instr[25:0], 2'b00}
                                   : pc_seq_or_br;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc <= '0;
      end else begin
         pc <= pc_next;
      end
   end

   assign pc_o       = pc;
   assign instr_o    = instr;
   assign rf_we_o    = rf_we;
   assign rf_waddr_o = waddr;
   assign rf_wdata_o = result;
   assign dm_we_o    = dm_we;
   assign dm_addr_o  = alu_y;
   assign dm_wdata_o = rd2;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
   import sc_pkg::*;
(
   input logic        clk,
   input logic        rst,
   input logic [31:0] pc_o,
   input logic [31:0] instr_o,
   input logic        rf_we_o,
   input logic        dm_we_o,
   input logic [31:0] rs_val,
   input logic [31:0] rt_val
);
   logic [5:0]  opc;
   logic [31:0] simm;
   logic [31:0] pc4;
   logic [31:0] btgt;
   logic [31:0] jtgt;
   logic        known;

   assign opc   = instr_o[31:26];
   assign simm  = {{16{instr_o[15]}}, instr_o[15:0]};
   assign pc4   = pc_o + 32'd4;
   assign btgt  = pc4 + (simm << 2);
   assign jtgt  = {pc4[31:28], instr_o[25:0], 2'b00};
   assign known = (opc == OPC_REG) || (opc == OPC_LOAD) || (opc == OPC_STORE) ||
                  (opc == OPC_BEQ) || (opc == OPC_ADDI) || (opc == OPC_JMP);

   a_r1_pc_zero_after_reset: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> pc_o == 32'd0);

   a_r2_sequential_step: assert property (@(posedge clk) disable iff (rst)
      (opc != OPC_BEQ && opc != OPC_JMP) |=> pc_o == $past(pc4));

   a_r7_branch_taken: assert property (@(posedge clk) disable iff (rst)
      (opc == OPC_BEQ && rs_val == rt_val) |=> pc_o == $past(btgt));

   a_r7_branch_not_taken: assert property (@(posedge clk) disable iff (rst)
      (opc == OPC_BEQ && rs_val != rt_val) |=> pc_o == $past(pc4));

   a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
      (opc == OPC_JMP) |=> pc_o == $past(jtgt));

   a_r6_store_only: assert property (@(posedge clk) disable iff (rst)
      (opc == OPC_STORE) |-> (dm_we_o && !rf_we_o));

   a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
      !known |-> (!rf_we_o && !dm_we_o));
endmodule

bind sc_core sc_core_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .pc_o    (pc_o),
   .instr_o (instr_o),
   .rf_we_o (rf_we_o),
   .dm_we_o (dm_we_o),
   .rs_val  (rd1),
   .rt_val  (rd2)
);

// File: tb/sc_core_test.sv
module sc_core_test;
   localparam int IW = 64;
   localparam int DW = 64;
   localparam int LAW = 6;
   localparam int RUN_CYCLES = 3000;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           ld_en = 1'b0;
   logic           ld_dmem = 1'b0;
   logic [LAW-1:0] ld_addr = '0;
   logic [31:0]    ld_data = '0;
   logic [31:0]    pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
   logic [4:0]     rf_waddr_o;
   logic           rf_we_o, dm_we_o;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_im [IW];
   logic [31:0] m_dm [DW];
   logic [31:0] m_rf [32];
   logic [31:0] m_pc;

   always #5 clk = ~clk;

   sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) uut (
      .clk, .rst, .ld_en, .ld_dmem, .ld_addr, .ld_data,
      .pc_o, .instr_o, .rf_we_o, .rf_waddr_o, .rf_wdata_o,
      .dm_we_o, .dm_addr_o, .dm_wdata_o
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h (pc %h)", tag, what, act, exp, m_pc);
      end
   endtask

   function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                         input logic [5:0] fn);
      return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                         input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   function automatic logic [31:0] sext(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   function automatic logic [31:0] ref_alu(input logic [5:0] fn, input logic [31:0] a,
                                           input logic [31:0] b);
      case (fn)
         6'b100001: return a + b;
         6'b100011: return a - b;
         6'b100100: return a & b;
         6'b100101: return a | b;
         6'b101010: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         default:   return a + b;
      endcase
   endfunction

   task automatic load_word(input logic sel, input int idx, input logic [31:0] w);
      @(negedge clk);
      ld_en = 1'b1; ld_dmem = sel; ld_addr = LAW'(idx); ld_data = w;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   // compare one executed instruction and advance the model
   task automatic step_and_check();
      logic [31:0] ins, a, b, addr, nxt, wd;
      logic [5:0]  op;
      logic [4:0]  rs, rt, rd;
      logic        exp_rf, exp_dm;
      logic [4:0]  exp_wa;
      string       t, pt;
      ins = m_im[m_pc[7:2]];
      op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
      a = m_rf[rs]; b = m_rf[rt];
      addr = a + sext(ins[15:0]);
      exp_rf = 1'b0; exp_dm = 1'b0; exp_wa = '0; wd = '0;
      nxt = m_pc + 32'd4;
      pt = "R2";
      case (op)
         6'b000000: begin t = "R3"; exp_rf = 1'b1; exp_wa = rd; wd = ref_alu(ins[5:0], a, b); end
         6'b001001: begin t = "R4"; exp_rf = 1'b1; exp_wa = rt; wd = addr; end
         6'b100011: begin t = "R5"; exp_rf = 1'b1; exp_wa = rt; wd = m_dm[addr[7:2]]; end
         6'b101011: begin t = "R6"; exp_dm = 1'b1; end
         6'b000100: begin
            t = "R7"; pt = "R7";
            if (a == b) nxt = m_pc + 32'd4 + (sext(ins[15:0]) << 2);
         end
         6'b000010: begin
            t = "R8"; pt = "R8";
            nxt = {nxt[31:28], ins[25:0], 2'b00};
         end
         default: t = "R10";
      endcase
      if (rs == 0 || (rt == 0 && (op == 6'b000000 || op == 6'b101011))) t = "R9";
      chk(pt, "pc", pc_o, m_pc);
      chk("R2", "instr", instr_o, ins);
      chk(t, "rf_we", 32'(rf_we_o), 32'(exp_rf));
      chk(t, "dm_we", 32'(dm_we_o), 32'(exp_dm));
      if (exp_rf) begin
         chk(t, "rf_waddr", 32'(rf_waddr_o), 32'(exp_wa));
         chk(t, "rf_wdata", rf_wdata_o, wd);
      end
      if (exp_dm) begin
         chk(t, "dm_addr", dm_addr_o, addr);
         chk(t, "dm_wdata", dm_wdata_o, b);
      end
      if (exp_rf && exp_wa != 0) m_rf[exp_wa] = wd;
      if (exp_dm) m_dm[addr[7:2]] = b;
      m_pc = nxt;
   endtask

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd20517);
      // directed prologue: dependent results, r0 write, store/load, branches, jump, unknown
      m_im[0]  = enc_i(6'b001001, 0, 1, 16'd5);
      m_im[1]  = enc_i(6'b001001, 0, 2, 16'hFFFD);
      m_im[2]  = enc_r(2, 1, 3, 6'b101010);
      m_im[3]  = enc_r(1, 2, 4, 6'b100011);
      m_im[4]  = enc_r(1, 1, 0, 6'b100001);
      m_im[5]  = enc_r(0, 0, 5, 6'b100001);
      m_im[6]  = enc_i(6'b101011, 0, 1, 16'd8);
      m_im[7]  = enc_i(6'b100011, 0, 6, 16'd8);
      m_im[8]  = enc_i(6'b000100, 1, 1, 16'd1);
      m_im[9]  = enc_i(6'b001001, 0, 7, 16'd1);
      m_im[10] = enc_i(6'b000100, 1, 2, 16'd5);
      m_im[11] = {6'b000010, 26'd13};
      m_im[12] = enc_i(6'b001001, 0, 7, 16'd2);
      m_im[13] = 32'hFC00_0000;
      m_im[14] = enc_r(3, 4, 8, 6'b100100);
      m_im[15] = enc_r(3, 4, 9, 6'b100101);
      for (int i = 16; i < IW; i++) begin
         int kind, rs, rt, rd;
         kind = int'($urandom % 12);
         rs = int'($urandom % 8); rt = int'($urandom % 8); rd = int'($urandom % 8);
         case (kind)
            0, 1, 2, 3: begin
               logic [5:0] fns [5];
               fns = '{6'b100001, 6'b100011, 6'b100100, 6'b100101, 6'b101010};
               m_im[i] = enc_r(rs, rt, rd, fns[$urandom % 5]);
            end
            4, 5:    m_im[i] = enc_i(6'b001001, rs, rt, 16'($urandom));
            6:       m_im[i] = enc_i(6'b100011, rs, rt, 16'($urandom % 256));
            7:       m_im[i] = enc_i(6'b101011, rs, rt, 16'($urandom % 256));
            8:       m_im[i] = enc_i(6'b000100, rs, ((kind + i) % 3 == 0) ? rs : rt,
                                     16'(int'($urandom % 16) - 8));
            9:       m_im[i] = {6'b000010, 26'($urandom)};
            10:      m_im[i] = {6'b111111, 26'($urandom)};
            default: m_im[i] = enc_r(rs, 0, rd, 6'b101010);
         endcase
      end
      for (int i = 0; i < DW; i++) m_dm[i] = $urandom;
      for (int i = 0; i < 32; i++) m_rf[i] = '0;
      m_pc = '0;

      // load both stores while held in reset (R11)
      for (int i = 0; i < IW; i++) load_word(1'b0, i, m_im[i]);
      for (int i = 0; i < DW; i++) load_word(1'b1, i, m_dm[i]);
      @(negedge clk);
      chk("R1", "pc in reset", pc_o, 32'd0);
      chk("R1", "rf_we in reset", 32'(rf_we_o), 32'd0);
      chk("R1", "dm_we in reset", 32'(dm_we_o), 32'd0);
      chk("R11", "loaded word 0", instr_o, m_im[0]);

      rst = 1'b0;
      #1;
      for (int c = 0; c < RUN_CYCLES; c++) begin
         step_and_check();
         @(negedge clk);
         #1;
      end

      // reset again mid-program: PC returns to zero, registers clear (R1)
      rst = 1'b1;
      @(negedge clk);
      chk("R1", "pc after re-reset", pc_o, 32'd0);
      rst = 1'b0;
      for (int i = 0; i < 32; i++) m_rf[i] = '0;
      m_pc = '0;
      #1;
      for (int c = 0; c < 40; c++) begin
         step_and_check();
         @(negedge clk);
         #1;
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule